// File: doc/BRIEF.md
# Multi-Rate Sample Strobe Generator

This block drives the sample cadence of a multirate filter whose logic all runs on one control clock. That clock is picked as a common multiple of every sample rate the filter must handle. No derived clocks are produced. Instead, two single-cycle strobes mark the cycles in which the filter takes an input sample and in which it emits an output sample. Each strobe follows its own fractional ratio: N strobes in every M control cycles. The strobes may therefore be unevenly spaced. For example, a 15-of-16 pattern leaves out one cycle in sixteen.

A configuration write supplies both ratios, a polyphase interpolation factor and a fixed-point gain word. The gain word lets the datapath keep its scaling consistent for each pair of rates. A write made while the strobes are running is held back. It is applied only on the edge where both fractional accumulators come back to zero together, so no period is ever cut short. A phase index goes with every output strobe so that the filter can pick its coefficient phase. If a configuration is invalid, the block reports an error and keeps both strobes low.

The control is a four-state machine:
- `ST_IDLE`: after reset, with no configuration yet.
- `ST_RUN`: strobes active.
- `ST_PEND`: strobes active and a new configuration waiting.
- `ST_ERR`: an invalid configuration is in force.

The transitions are:
- `IDLE→RUN` or `IDLE→ERR`: a write, valid or invalid, is applied at once.
- `ERR→RUN` or `ERR→ERR`: a write is applied at once.
- `RUN→PEND`: any write.
- `PEND→PEND`: no common zero yet. A further write replaces the waiting one.
- `PEND→RUN` or `PEND→ERR`: at the common zero, depending on whether the applied configuration is valid.

Top module: `mrate_strobe_gen`

## Requirements
- R1: After synchronous reset, and until the first write, both strobes are low, `cfg_err` is low, and `gain_word` equals unity (1 << GAIN_FRAC, i.e. 16384 by default).
- R2: A write sampled while idle or in error takes effect at that same edge. `gain_word` and `cfg_err` show the new configuration one cycle later, and strobes may start on the following edge.
- R3: Counting the control edges after a configuration is applied as k = 1, 2, ..., `in_stb` is high after edge k exactly when floor(k·N_in/M_in) > floor((k-1)·N_in/M_in). Each strobe lasts one cycle.
- R4: `out_stb` follows the same rule with N_out/M_out, independently of the input side.
- R5: When N equals M on one side, that strobe is high on every cycle while running.
- R6: `gain_word` equals the gain field of the configuration currently applied.
- R7: A write made while running is not applied until the first later edge at which both accumulators return to zero. Until then, the strobes, gain and phase keep the old configuration. A second write before that edge replaces the first.
- R8: A configuration is invalid if N is 0 or N > M on either side, or if the interpolation factor is 0 or greater than 2^PHASE_W. Applying an invalid configuration raises `cfg_err` and sets `gain_word` to unity. Both strobes then stay low until a valid write is applied.
- R9: With each `out_stb`, `phase_idx` shows 0, 1, …, I−1, 0, … for interpolation factor I. Applying a configuration restarts the sequence at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_in_num | input | ACC_W | Input-side pulses per period (N_in) |
| cfg_in_den | input | ACC_W | Input-side period in cycles (M_in) |
| cfg_out_num | input | ACC_W | Output-side pulses per period (N_out) |
| cfg_out_den | input | ACC_W | Output-side period in cycles (M_out) |
| cfg_interp | input | PHASE_W+1 | Interpolation factor for the phase index |
| cfg_gain | input | GAIN_W | Fixed-point gain tied to this rate pair |
| in_stb | output | 1 | Input-sample strobe |
| out_stb | output | 1 | Output-sample strobe |
| phase_idx | output | PHASE_W | Polyphase index accompanying `out_stb` |
| gain_word | output | GAIN_W | Applied gain word |
| cfg_err | output | 1 | Invalid configuration in force |

## Verification
A write seen while idle or in error shows on `gain_word` and `cfg_err` one cycle after the edge that samples it. The first strobes can appear only one edge after that. A write made while running shows up at the edge of the next common zero, and the strobes of that same edge still belong to the old configuration. The bench steps a rate model once per edge, counting k from the edge of application, and evaluates the floor rule and the common-zero condition itself. For every edge, the driver queues the expected strobes, phase, gain and error flag. The monitor pops one entry 1 ns after each rising edge, so every comparison lands in the cycle the result is due.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2,
        ST_ERR  = 2'd3
    } mrs_state_t;

    localparam int CH_IN  = 0;
    localparam int CH_OUT = 1;
    localparam int NUM_CH = 2;

endpackage

// File: rtl/mrs_frac_acc.sv
module mrs_frac_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             clr,
    input  logic [ACC_W-1:0] num,
    input  logic [ACC_W-1:0] den,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] acc_nxt,
    output logic             wrap
);

    logic [ACC_W:0] sum;

    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, num};
        wrap = adv && (sum >= {1'b0, den});
        if (!adv) begin
            acc_nxt = acc_q;
        end else if (wrap) begin
            acc_nxt = ACC_W'(sum - {1'b0, den});
        end else begin
            acc_nxt = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_nxt;
        end
    end

    // Residue must stay inside the period while the ratio is in use
    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
        adv |-> (acc_q < den)); // R3

endmodule

// File: rtl/mrs_phase_ctr.sv
module mrs_phase_ctr #(
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               step,
    input  logic [PHASE_W:0]   factor,
    output logic [PHASE_W-1:0] phase_q
);

    logic [PHASE_W-1:0] cnt;
    logic [PHASE_W:0]   cnt_inc;
    logic               at_last;

    always_comb begin
        cnt_inc = {1'b0, cnt} + 1'b1;
        at_last = (cnt_inc >= factor);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            phase_q <= '0;
        end else begin
            if (step) begin
                phase_q <= cnt;
            end
            if (clr) begin
                cnt <= '0;
            end else if (step) begin
                cnt <= at_last ? '0 : cnt_inc[PHASE_W-1:0];
            end
        end
    end

    AST_PHASE_BELOW_FACTOR: assert property (@(posedge clk) disable iff (rst)
        step |-> ({1'b0, cnt} < factor)); // R9

endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
    import mrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       new_ok,
    input  logic       pend_ok,
    input  logic       common,
    output logic       adv,
    output logic       load,
    output logic       take_new,
    output logic       capture,
    output logic       apply_ok,
    output logic       err_state
);

    mrs_state_t state_q;
    mrs_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-state controls
    always_comb begin
        state_d  = state_q;
        adv      = 1'b0;
        load     = 1'b0;
        take_new = 1'b1;
        capture  = 1'b0;
        apply_ok = new_ok;
        unique case (state_q)
            ST_IDLE, ST_ERR: begin
                load = cfg_wr;
                if (cfg_wr) begin
                    state_d = new_ok ? ST_RUN : ST_ERR;
                end
            end
            ST_RUN: begin
                adv     = 1'b1;
                capture = cfg_wr;
                if (cfg_wr) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                adv      = 1'b1;
                take_new = cfg_wr;
                apply_ok = cfg_wr ? new_ok : pend_ok;
                capture  = cfg_wr && !common;
                load     = common;
                if (common) begin
                    state_d = apply_ok ? ST_RUN : ST_ERR;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        err_state = (state_q == ST_ERR);
    end

    AST_ERR_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ERR && !cfg_wr) |=> (state_q == ST_ERR)); // R8

endmodule

// File: rtl/mrate_strobe_gen.sv
module mrate_strobe_gen
    import mrs_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int PHASE_W   = 3,
    parameter int GAIN_W    = 18,
    parameter int GAIN_FRAC = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [ACC_W-1:0]   cfg_in_num,
    input  logic [ACC_W-1:0]   cfg_in_den,
    input  logic [ACC_W-1:0]   cfg_out_num,
    input  logic [ACC_W-1:0]   cfg_out_den,
    input  logic [PHASE_W:0]   cfg_interp,
    input  logic [GAIN_W-1:0]  cfg_gain,
    output logic               in_stb,
    output logic               out_stb,
    output logic [PHASE_W-1:0] phase_idx,
    output logic [GAIN_W-1:0]  gain_word,
    output logic               cfg_err
);

    localparam logic [GAIN_W-1:0] UNITY      = GAIN_W'(1) << GAIN_FRAC;
    localparam int unsigned       MAX_FACTOR = 1 << PHASE_W;

    // Pending and applied configuration
    logic [ACC_W-1:0]  pend_num [NUM_CH];
    logic [ACC_W-1:0]  pend_den [NUM_CH];
    logic [PHASE_W:0]  pend_interp;
    logic [GAIN_W-1:0] pend_gain;
    logic [ACC_W-1:0]  act_num  [NUM_CH];
    logic [ACC_W-1:0]  act_den  [NUM_CH];
    logic [PHASE_W:0]  act_interp;
    logic [GAIN_W-1:0] act_gain;

    logic [ACC_W-1:0]  wr_num   [NUM_CH];
    logic [ACC_W-1:0]  wr_den   [NUM_CH];

    logic [ACC_W-1:0]  acc_q    [NUM_CH];
    logic [ACC_W-1:0]  acc_nxt  [NUM_CH];
    logic [NUM_CH-1:0] wrap;

    logic new_ok, pend_ok, common;
    logic adv, load, take_new, capture, apply_ok, err_state;
    logic in_stb_q, out_stb_q;

    function automatic logic ratio_ok(input logic [ACC_W-1:0] n, input logic [ACC_W-1:0] d);
        return (n != '0) && (n <= d);
    endfunction

    function automatic logic factor_ok(input logic [PHASE_W:0] f);
        return (f != '0) && (32'(f) <= MAX_FACTOR);
    endfunction

    always_comb begin
        wr_num[CH_IN]  = cfg_in_num;
        wr_den[CH_IN]  = cfg_in_den;
        wr_num[CH_OUT] = cfg_out_num;
        wr_den[CH_OUT] = cfg_out_den;
        new_ok  = ratio_ok(cfg_in_num, cfg_in_den) && ratio_ok(cfg_out_num, cfg_out_den)
                  && factor_ok(cfg_interp);
        pend_ok = ratio_ok(pend_num[CH_IN], pend_den[CH_IN])
                  && ratio_ok(pend_num[CH_OUT], pend_den[CH_OUT])
                  && factor_ok(pend_interp);
        common  = (acc_nxt[CH_IN] == '0) && (acc_nxt[CH_OUT] == '0);
    end

    mrs_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .new_ok    (new_ok),
        .pend_ok   (pend_ok),
        .common    (common),
        .adv       (adv),
        .load      (load),
        .take_new  (take_new),
        .capture   (capture),
        .apply_ok  (apply_ok),
        .err_state (err_state)
    );

    // Configuration storage; per-channel fields repeat
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_num[ch] <= '0;
                pend_den[ch] <= '0;
                act_num[ch]  <= '0;
                act_den[ch]  <= '0;
            end else begin
                if (capture) begin
                    pend_num[ch] <= wr_num[ch];
                    pend_den[ch] <= wr_den[ch];
                end
                if (load) begin
                    act_num[ch] <= take_new ? wr_num[ch] : pend_num[ch];
                    act_den[ch] <= take_new ? wr_den[ch] : pend_den[ch];
                end
            end
        end

        mrs_frac_acc #(
            .ACC_W (ACC_W)
        ) u_acc (
            .clk     (clk),
            .rst     (rst),
            .adv     (adv),
            .clr     (load),
            .num     (act_num[ch]),
            .den     (act_den[ch]),
            .acc_q   (acc_q[ch]),
            .acc_nxt (acc_nxt[ch]),
            .wrap    (wrap[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_interp <= '0;
            pend_gain   <= '0;
            act_interp  <= '0;
            act_gain    <= UNITY;
        end else begin
            if (capture) begin
                pend_interp <= cfg_interp;
                pend_gain   <= cfg_gain;
            end
            if (load) begin
                act_interp <= take_new ? cfg_interp : pend_interp;
                if (apply_ok) begin
                    act_gain <= take_new ? cfg_gain : pend_gain;
                end else begin
                    act_gain <= UNITY;
                end
            end
        end
    end

    // Output strobes, one register stage after the accumulator wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            in_stb_q  <= 1'b0;
            out_stb_q <= 1'b0;
        end else begin
            in_stb_q  <= wrap[CH_IN];
            out_stb_q <= wrap[CH_OUT];
        end
    end

    mrs_phase_ctr #(
        .PHASE_W (PHASE_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .clr     (load),
        .step    (wrap[CH_OUT]),
        .factor  (act_interp),
        .phase_q (phase_idx)
    );

    always_comb begin
        in_stb    = in_stb_q;
        out_stb   = out_stb_q;
        gain_word = act_gain;
        cfg_err   = err_state;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!in_stb && !out_stb && !cfg_err && gain_word == UNITY)); // R1

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && $past(cfg_err)) |-> (!in_stb && !out_stb)); // R8

    AST_GAIN_AT_COMMON: assert property (@(posedge clk) disable iff (rst)
        !$stable(gain_word) |-> (acc_q[CH_IN] == '0 && acc_q[CH_OUT] == '0)); // R7

endmodule

// File: tb/mrate_strobe_gen_tb.sv
module mrate_strobe_gen_tb;

    localparam int ACC_W     = 16;
    localparam int PHASE_W   = 3;
    localparam int GAIN_W    = 18;
    localparam int GAIN_FRAC = 14;
    localparam int UNITY     = 1 << GAIN_FRAC;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_wr = 1'b0;
    logic [ACC_W-1:0]   cfg_in_num = '0, cfg_in_den = '0;
    logic [ACC_W-1:0]   cfg_out_num = '0, cfg_out_den = '0;
    logic [PHASE_W:0]   cfg_interp = '0;
    logic [GAIN_W-1:0]  cfg_gain = '0;
    logic               in_stb, out_stb, cfg_err;
    logic [PHASE_W-1:0] phase_idx;
    logic [GAIN_W-1:0]  gain_word;

    always #2 clk = ~clk;

    mrate_strobe_gen #(
        .ACC_W (ACC_W), .PHASE_W (PHASE_W), .GAIN_W (GAIN_W), .GAIN_FRAC (GAIN_FRAC)
    ) u_dut (
        .clk (clk), .rst (rst), .cfg_wr (cfg_wr),
        .cfg_in_num (cfg_in_num), .cfg_in_den (cfg_in_den),
        .cfg_out_num (cfg_out_num), .cfg_out_den (cfg_out_den),
        .cfg_interp (cfg_interp), .cfg_gain (cfg_gain),
        .in_stb (in_stb), .out_stb (out_stb), .phase_idx (phase_idx),
        .gain_word (gain_word), .cfg_err (cfg_err)
    );

    typedef struct {
        bit    in_s;
        bit    out_s;
        bit    ph_chk;
        int    ph;
        int    gain;
        bit    err;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Rate model state
    bit     m_run = 0, m_pend = 0, m_err = 0;
    longint k = 0;
    int     m_gain = UNITY, ph = 0;
    int     a_ni, a_mi, a_no, a_mo, a_ii;
    int     p_ni, p_mi, p_no, p_mo, p_ii, p_g;

    function automatic bit cfg_valid(int ni, int mi, int no, int mo, int ii);
        return ni != 0 && ni <= mi && no != 0 && no <= mo && ii != 0 && ii <= (1 << PHASE_W);
    endfunction

    task automatic apply_cfg(int ni, int mi, int no, int mo, int ii, int g);
        bit v;
        v = cfg_valid(ni, mi, no, mo, ii);
        a_ni = ni; a_mi = mi; a_no = no; a_mo = mo; a_ii = ii;
        m_err  = !v;
        m_gain = v ? g : UNITY;
        m_run  = v;
        m_pend = 0;
        k      = 0;
        ph     = 0;
    endtask

    // Driver: one control edge per call, expectation pushed for that edge
    task automatic step(bit r, bit w, int ni, int mi, int no, int mo, int ii, int g, string tag);
        exp_t e;
        bit   common;
        e.in_s = 0; e.out_s = 0; e.ph_chk = 0; e.ph = 0; e.tag = tag;
        if (r) begin
            m_run = 0; m_pend = 0; m_err = 0; m_gain = UNITY; ph = 0; k = 0;
        end else begin
            common = 1;
            if (m_run) begin
                k++;
                e.in_s  = ((k * a_ni) / a_mi) != (((k - 1) * a_ni) / a_mi);
                e.out_s = ((k * a_no) / a_mo) != (((k - 1) * a_no) / a_mo);
                if (e.out_s) begin
                    e.ph_chk = 1; e.ph = ph; ph = (ph + 1) % a_ii;
                end
                common = ((k * a_ni) % a_mi == 0) && ((k * a_no) % a_mo == 0);
            end
            if (!m_run) begin
                if (w) apply_cfg(ni, mi, no, mo, ii, g);
            end else if (m_pend) begin
                if (common) begin
                    if (w) apply_cfg(ni, mi, no, mo, ii, g);
                    else   apply_cfg(p_ni, p_mi, p_no, p_mo, p_ii, p_g);
                end else if (w) begin
                    p_ni = ni; p_mi = mi; p_no = no; p_mo = mo; p_ii = ii; p_g = g;
                end
            end else if (w) begin
                p_ni = ni; p_mi = mi; p_no = no; p_mo = mo; p_ii = ii; p_g = g;
                m_pend = 1;
            end
        end
        e.gain = m_gain;
        e.err  = m_err;
        rst         = r;
        cfg_wr      = w;
        cfg_in_num  = 16'(ni); cfg_in_den  = 16'(mi);
        cfg_out_num = 16'(no); cfg_out_den = 16'(mo);
        cfg_interp  = 4'(ii);
        cfg_gain    = 18'(g);
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic chk(bit ok, string tag, string what, int got, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %0d exp %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Monitor: pops one expectation 1 ns after every rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(in_stb == e.in_s, e.tag, "R3 in_stb", int'(in_stb), int'(e.in_s));
                chk(out_stb == e.out_s, e.tag, "R4 out_stb", int'(out_stb), int'(e.out_s));
                chk(int'(gain_word) == e.gain, e.tag, "R6 gain_word", int'(gain_word), e.gain);
                chk(cfg_err == e.err, e.tag, "R8 cfg_err", int'(cfg_err), int'(e.err));
                if (e.ph_chk)
                    chk(int'(phase_idx) == e.ph, e.tag, "R9 phase_idx", int'(phase_idx), e.ph);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 got hung exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state and idle with no configuration
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
        idle(4, "R1");
        // R2: immediate apply from idle; R3/R4 patterns 3-of-5 and 2-of-3
        step(0, 1, 3, 5, 2, 3, 3, 20000, "R2");
        idle(40, "R3");
        // R7: deferred write, then replaced before the common zero
        step(0, 1, 1, 4, 4, 4, 4, 12345, "R7");
        idle(1, "R7");
        step(0, 1, 1, 2, 4, 4, 4, 12345, "R7");
        // R5: output side N equals M after the swap
        idle(30, "R5");
        // R8: invalid ratio (N > M) deferred, then error
        step(0, 1, 5, 4, 1, 1, 2, 100, "R8");
        idle(10, "R8");
        step(0, 1, 0, 4, 1, 1, 2, 100, "R8");
        idle(3, "R8");
        step(0, 1, 1, 4, 1, 1, 0, 100, "R8");
        idle(3, "R8");
        // R9: 15-of-16 input, 1-of-16 output, phase over factor 8
        step(0, 1, 15, 16, 1, 16, 8, 8192, "R9");
        idle(150, "R9");
        // R1: reset while running
        step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
        idle(5, "R1");
        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule